// File: doc/BRIEF.md
# Memory Scrub Address Sequencer

This block produces the stream of line addresses that a memory controller walks through for background ECC scrubbing. Each periodic tick asks for one read-correct-write scrub at the current line, which is one 128-byte line above the last. The address counter runs from a start line up to a limit boundary, then returns to the start. A demand input can also insert a scrub at an address supplied from outside. It bypasses the counter and does not disturb it.

Software programs the block through two 32-bit control registers, a limit register and a start register. Each has a self-clearing valid flag. New start, limit and periodic-mask values are held in staging until the next address update, which is the acceptance of a periodic scrub. So exactly one more scrub runs on the old counter address before a new start takes over. The demand write mask is not staged and acts on the next demand request at once.

The request side is a small state machine with three states. `S_IDLE` waits for work. `S_PER` presents a periodic scrub, and `S_DMD` presents a demand scrub. Its transitions are:
- `S_IDLE`→`S_DMD` when a demand is offered. This has priority.
- `S_IDLE`→`S_PER` when a tick is pending.
- `S_PER`→`S_IDLE` and `S_DMD`→`S_IDLE` when the request is accepted.

Top module: `scrub_addr_seq`

## Requirements
- R1: After reset both registers read 0, no request is presented (`req_valid` low) and `dmd_ready` is high.
- R2: Register field positions are as follows, and every other bit reads 0.
  - Limit register (`cfg_sel`=0): bit 31 is the valid flag, bit 28 the periodic write mask, bit 27 the demand write mask, and bits 14:0 the limit (physical address bits 34:20).
  - Start register (`cfg_sel`=1): bit 31 is the valid flag and bits 27:0 the start line (physical address bits 34:7).
- R3: Writing a register with bit 31 set makes bit 31 read 1. The flag goes back to 0 when the next periodic scrub is accepted. Writing bit 31 as 0 leaves the flag unchanged.
- R4: After the start register is written with its valid flag, the next periodic scrub still uses the old counter address. The one after it uses the new start line.
- R5: Each accepted periodic scrub advances the line address by one. When the incremented value reaches limit×8192, the address returns to the start line. With a limit of 0, every scrub uses the start line. Nothing else changes the counter.
- R6: `req_wr_en` of a periodic request is the inverse of the active periodic mask. A written mask becomes active only through the valid flag, at the next accepted periodic scrub. The scrub accepted at that moment still uses the old mask.
- R7: `req_wr_en` of a demand request is the inverse of the demand mask bit currently in the limit register. No valid flag is needed.
- R8: A demand is accepted only while `dmd_ready` is high, which is only in the idle state. Its request carries `dmd_addr` with `req_is_dmd` high, and it leaves the counter unchanged.
- R9: While `req_valid` is high and `req_ready` is low, the request stays valid with the same `req_addr` and `req_is_dmd`.
- R10: A tick pulse on a clock edge in idle presents a periodic request after the second edge. A tick that arrives while a demand is being accepted is remembered. A demand offered together with a pending tick is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 limit, 1 start |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| tick | input | 1 | Periodic scrub tick |
| dmd_valid | input | 1 | Demand scrub offered |
| dmd_ready | output | 1 | Demand scrub can be accepted |
| dmd_addr | input | 28 | Demand scrub line address |
| req_valid | output | 1 | Scrub request present |
| req_ready | input | 1 | Scrub request accepted |
| req_addr | output | 28 | Line address to scrub |
| req_wr_en | output | 1 | Perform the write-back phase |
| req_is_dmd | output | 1 | Request is a demand scrub |

## Verification
The assertions check several properties on every cycle:
- a request held under back-pressure stays stable;
- `dmd_ready` and `req_valid` are never high together;
- a demand request's write enable follows the live demand mask;
- both valid flags clear after an accepted periodic scrub;
- the counter moves only on such an acceptance;
- the reserved limit bits read zero.

Some behaviour depends on a sequence of scrubs and only the directed scenarios can show it:
- the single extra scrub on the old address;
- the wrap from the last line before the limit back to the start;
- the delayed take-over of the periodic mask;
- the limit-zero case;
- demand priority over a pending tick.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PER  = 2'd1,
        S_DMD  = 2'd2
    } scrub_state_e;

    localparam int VALID_BIT = 31;
    localparam int PMASK_BIT = 28;
    localparam int DMASK_BIT = 27;

endpackage

// File: rtl/scrub_cfg_regs.sv
module scrub_cfg_regs
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int LIM_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              load,
    output logic [31:0]       cfg_rdata,
    output logic [ADDR_W-1:0] start_q,
    output logic              start_pend,
    output logic [LIM_W-1:0]  lim_q,
    output logic              lim_pend,
    output logic              pmask_q,
    output logic              dmask_q
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{cfg_wdata[30:29], cfg_wdata[26:LIM_W], cfg_wdata[30:ADDR_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            start_pend <= 1'b0;
            lim_q      <= '0;
            lim_pend   <= 1'b0;
            pmask_q    <= 1'b0;
            dmask_q    <= 1'b0;
        end else begin
            // an update consumes the staged values; a same-cycle write re-arms
            if (load) begin
                start_pend <= 1'b0;
                lim_pend   <= 1'b0;
            end
            if (cfg_we && !cfg_sel) begin
                lim_q   <= cfg_wdata[LIM_W-1:0];
                pmask_q <= cfg_wdata[PMASK_BIT];
                dmask_q <= cfg_wdata[DMASK_BIT];
                if (cfg_wdata[VALID_BIT]) lim_pend <= 1'b1;
            end
            if (cfg_we && cfg_sel) begin
                start_q <= cfg_wdata[ADDR_W-1:0];
                if (cfg_wdata[VALID_BIT]) start_pend <= 1'b1;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (!cfg_sel) begin
            cfg_rdata[VALID_BIT]   = lim_pend;
            cfg_rdata[PMASK_BIT]   = pmask_q;
            cfg_rdata[DMASK_BIT]   = dmask_q;
            cfg_rdata[LIM_W-1:0]   = lim_q;
        end else begin
            cfg_rdata[VALID_BIT]   = start_pend;
            cfg_rdata[ADDR_W-1:0]  = start_q;
        end
    end

endmodule

// File: rtl/scrub_addr_ctr.sv
module scrub_addr_ctr #(
    parameter int ADDR_W = 28,
    parameter int LIM_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [ADDR_W-1:0] start_q,
    input  logic              start_pend,
    input  logic [LIM_W-1:0]  lim_q,
    input  logic              lim_pend,
    input  logic              pmask_q,
    output logic [ADDR_W-1:0] cnt,
    output logic              pmask_act
);

    localparam int LINE_SHIFT = ADDR_W - LIM_W;

    logic [ADDR_W-1:0] start_act;
    logic [LIM_W-1:0]  lim_act;
    logic [ADDR_W-1:0] eff_start;
    logic [LIM_W-1:0]  eff_lim;
    logic [ADDR_W:0]   inc;
    logic [ADDR_W:0]   bound;
    logic [ADDR_W-1:0] cnt_nxt;

    always_comb begin
        eff_start = start_pend ? start_q : start_act;
        eff_lim   = lim_pend   ? lim_q   : lim_act;
        inc       = {1'b0, cnt} + 1'b1;
        bound     = {1'b0, eff_lim, {LINE_SHIFT{1'b0}}};
        if (start_pend)
            cnt_nxt = start_q;
        else if (inc >= bound)
            cnt_nxt = eff_start;
        else
            cnt_nxt = inc[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            start_act <= '0;
            lim_act   <= '0;
            pmask_act <= 1'b0;
        end else if (advance) begin
            cnt       <= cnt_nxt;
            start_act <= eff_start;
            lim_act   <= eff_lim;
            if (lim_pend) pmask_act <= pmask_q;
        end
    end

endmodule

// File: rtl/scrub_req_fsm.sv
module scrub_req_fsm
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              dmd_valid,
    input  logic [ADDR_W-1:0] dmd_addr,
    input  logic              req_ready,
    input  logic [ADDR_W-1:0] cnt,
    input  logic              pmask_act,
    input  logic              dmask_q,
    output logic              dmd_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_wr_en,
    output logic              req_is_dmd,
    output logic              advance
);

    scrub_state_e      state_q, state_d;
    logic              tick_q;
    logic [ADDR_W-1:0] dmd_addr_q;
    logic              go_per;

    assign go_per = (state_q == S_IDLE) && !dmd_valid && tick_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q     <= 1'b0;
            dmd_addr_q <= '0;
        end else begin
            tick_q <= (tick_q && !go_per) || tick;
            if (state_q == S_IDLE && dmd_valid) dmd_addr_q <= dmd_addr;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (dmd_valid)   state_d = S_DMD;
                else if (tick_q) state_d = S_PER;
            end
            S_PER:  if (req_ready) state_d = S_IDLE;
            S_DMD:  if (req_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        dmd_ready  = 1'b0;
        req_valid  = 1'b0;
        req_addr   = '0;
        req_wr_en  = 1'b0;
        req_is_dmd = 1'b0;
        advance    = 1'b0;
        unique case (state_q)
            S_IDLE: dmd_ready = 1'b1;
            S_PER: begin
                req_valid = 1'b1;
                req_addr  = cnt;
                req_wr_en = !pmask_act;
                advance   = req_ready;
            end
            S_DMD: begin
                req_valid  = 1'b1;
                req_addr   = dmd_addr_q;
                req_wr_en  = !dmask_q;
                req_is_dmd = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scrub_addr_seq.sv
module scrub_addr_seq #(
    parameter int ADDR_W = 28,
    parameter int LIM_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              tick,
    input  logic              dmd_valid,
    output logic              dmd_ready,
    input  logic [ADDR_W-1:0] dmd_addr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_wr_en,
    output logic              req_is_dmd
);

    logic [ADDR_W-1:0] start_q;
    logic              start_pend;
    logic [LIM_W-1:0]  lim_q;
    logic              lim_pend;
    logic              pmask_q;
    logic              dmask_q;
    logic [ADDR_W-1:0] cnt;
    logic              pmask_act;
    logic              advance;

    scrub_cfg_regs #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .load(advance), .cfg_rdata(cfg_rdata),
        .start_q(start_q), .start_pend(start_pend), .lim_q(lim_q),
        .lim_pend(lim_pend), .pmask_q(pmask_q), .dmask_q(dmask_q)
    );

    scrub_addr_ctr #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .advance(advance), .start_q(start_q),
        .start_pend(start_pend), .lim_q(lim_q), .lim_pend(lim_pend),
        .pmask_q(pmask_q), .cnt(cnt), .pmask_act(pmask_act)
    );

    scrub_req_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dmd_valid(dmd_valid),
        .dmd_addr(dmd_addr), .req_ready(req_ready), .cnt(cnt),
        .pmask_act(pmask_act), .dmask_q(dmask_q), .dmd_ready(dmd_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_wr_en(req_wr_en),
        .req_is_dmd(req_is_dmd), .advance(advance)
    );

endmodule

// File: rtl/scrub_addr_seq_chk.sv
module scrub_addr_seq_chk #(
    parameter int ADDR_W = 28,
    parameter int LIM_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [31:0]       cfg_rdata,
    input logic              dmd_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_wr_en,
    input logic              req_is_dmd,
    input logic [ADDR_W-1:0] cnt,
    input logic              start_pend,
    input logic              lim_pend,
    input logic              dmask_q
);

    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_is_dmd));

    a_r8_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dmd_ready |-> !req_valid);

    a_r7_dmd_live_mask: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_is_dmd |-> req_wr_en == !dmask_q);

    a_r3_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_is_dmd && !cfg_we |=> !start_pend && !lim_pend);

    a_r5_cnt_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && !req_is_dmd) |=> $stable(cnt));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |-> cfg_rdata[30:29] == 2'b00 && cfg_rdata[26:LIM_W] == '0);

endmodule

bind scrub_addr_seq scrub_addr_seq_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_rdata(cfg_rdata), .dmd_ready(dmd_ready), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_wr_en(req_wr_en),
    .req_is_dmd(req_is_dmd), .cnt(cnt), .start_pend(start_pend),
    .lim_pend(lim_pend), .dmask_q(dmask_q)
);

// File: tb/scrub_addr_seq_tb.sv
`timescale 1ns/1ps
module scrub_addr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick = 1'b0;
    logic        dmd_valid = 1'b0;
    logic        dmd_ready;
    logic [27:0] dmd_addr = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [27:0] req_addr;
    logic        req_wr_en;
    logic        req_is_dmd;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scrub_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick(tick),
        .dmd_valid(dmd_valid), .dmd_ready(dmd_ready), .dmd_addr(dmd_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wr_en(req_wr_en), .req_is_dmd(req_is_dmd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic sel, input logic [31:0] exp, input string tag);
        cfg_sel = sel;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic wait_req(input logic [27:0] ea, input logic ew, input logic ed, input string tag);
        int n = 0;
        while (!req_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        check({tag, " valid"}, {31'b0, req_valid}, 32'd1);
        check({tag, " addr"},  {4'b0, req_addr}, {4'b0, ea});
        check({tag, " wr_en"}, {31'b0, req_wr_en}, {31'b0, ew});
        check({tag, " is_dmd"}, {31'b0, req_is_dmd}, {31'b0, ed});
        @(negedge clk);
    endtask

    task automatic periodic(input logic [27:0] ea, input logic ew, input string tag);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check({tag, " no req one edge after tick"}, {31'b0, req_valid}, 32'd0);
        wait_req(ea, ew, 1'b0, tag);
    endtask

    task automatic demand(input logic [27:0] a, input logic ew, input string tag);
        @(negedge clk);
        check({tag, " dmd_ready"}, {31'b0, dmd_ready}, 32'd1);
        dmd_valid = 1'b1; dmd_addr = a;
        @(negedge clk);
        dmd_valid = 1'b0;
        wait_req(a, ew, 1'b1, tag);
    endtask

    task automatic t_reset;
        cfg_read(1'b0, 32'h0, "R1 limit reg reset");
        cfg_read(1'b1, 32'h0, "R1 start reg reset");
        check("R1 req_valid reset", {31'b0, req_valid}, 32'd0);
        check("R1 dmd_ready reset", {31'b0, dmd_ready}, 32'd1);
    endtask

    task automatic t_staging;
        cfg_write(1'b1, 32'h8000_0100);
        cfg_write(1'b0, 32'h8000_0001);
        cfg_read(1'b1, 32'h8000_0100, "R3 start flag set");
        cfg_read(1'b0, 32'h8000_0001, "R3 limit flag set");
        periodic(28'h0, 1'b1, "R4 extra scrub on old address");
        cfg_read(1'b1, 32'h0000_0100, "R3 start flag cleared");
        cfg_read(1'b0, 32'h0000_0001, "R3 limit flag cleared");
        periodic(28'h100, 1'b1, "R4 new start used");
        periodic(28'h101, 1'b1, "R5 increment");
    endtask

    task automatic t_wrap;
        cfg_write(1'b1, 32'h8000_1FFE);
        periodic(28'h102, 1'b1, "R4 old counter once more");
        periodic(28'h1FFE, 1'b1, "R5 start near limit");
        periodic(28'h1FFF, 1'b1, "R5 last line below limit");
        periodic(28'h1FFE, 1'b1, "R5 wrap to start");
    endtask

    task automatic t_pmask;
        cfg_write(1'b0, 32'h1000_0001);
        cfg_read(1'b0, 32'h1000_0001, "R2 pmask field");
        periodic(28'h1FFF, 1'b1, "R6 mask without flag ignored");
        periodic(28'h1FFE, 1'b1, "R6 still ignored");
        cfg_write(1'b0, 32'h9000_0001);
        periodic(28'h1FFF, 1'b1, "R6 old mask at update");
        periodic(28'h1FFE, 1'b0, "R6 mask active");
    endtask

    task automatic t_demand;
        cfg_write(1'b0, 32'h0800_0001);
        demand(28'hABCDEF, 1'b0, "R7 demand mask immediate");
        cfg_write(1'b0, 32'h0000_0001);
        demand(28'h0000123, 1'b1, "R7 demand mask cleared");
        periodic(28'h1FFF, 1'b0, "R8 counter untouched by demand");
        cfg_write(1'b0, 32'h8000_0001);
        periodic(28'h1FFE, 1'b0, "R6 unmask loads at update");
    endtask

    task automatic t_stall;
        req_ready = 1'b0;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        check("R10 req after second edge", {31'b0, req_valid}, 32'd1);
        check("R9 stalled addr", {4'b0, req_addr}, 32'h1FFF);
        repeat (4) @(negedge clk);
        check("R9 held valid", {31'b0, req_valid}, 32'd1);
        check("R9 held addr", {4'b0, req_addr}, 32'h1FFF);
        check("R9 held wr_en", {31'b0, req_wr_en}, 32'd1);
        req_ready = 1'b1;
        @(negedge clk);
        check("R9 released", {31'b0, req_valid}, 32'd0);
        periodic(28'h1FFE, 1'b1, "R5 single advance after stall");
    endtask

    task automatic t_priority;
        @(negedge clk);
        tick = 1'b1; dmd_valid = 1'b1; dmd_addr = 28'h77;
        @(negedge clk);
        tick = 1'b0; dmd_valid = 1'b0;
        wait_req(28'h77, 1'b1, 1'b1, "R10 demand first");
        wait_req(28'h1FFF, 1'b1, 1'b0, "R10 remembered tick");
    endtask

    task automatic t_reserved;
        cfg_write(1'b0, 32'h7FFF_FFFF);
        cfg_read(1'b0, 32'h1800_7FFF, "R2 limit reserved zero");
        cfg_write(1'b1, 32'h7FFF_FFFF);
        cfg_read(1'b1, 32'h0FFF_FFFF, "R2 start reserved zero");
    endtask

    task automatic t_limit_zero;
        cfg_write(1'b0, 32'h8000_0000);
        cfg_write(1'b1, 32'h8000_0055);
        periodic(28'h1FFE, 1'b1, "R4 extra before limit zero");
        periodic(28'h55, 1'b1, "R5 limit zero start");
        periodic(28'h55, 1'b1, "R5 limit zero repeats start");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_staging();
        t_wrap();
        t_pmask();
        t_demand();
        t_stall();
        t_priority();
        t_reserved();
        t_limit_zero();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule